// File: doc/BRIEF.md
# All-Ones Alarm Detector

This block watches a received NRZ bit stream, taking one bit on each cycle where a qualifying strobe is high. It looks for the all-ones alarm pattern that a far end sends in place of traffic. Strobed bits are grouped into back-to-back windows of a fixed length, 8192 bits by default, which is about 5.3 ms at the T1 line rate. The block counts the zeros in each window. A window with too few zeros (fewer than 9 by default, so at least 99.9% ones) raises the alarm. A window with at least that many zeros drops it.

The alarm is reported in three ways. There is a live status bit. There is a sticky event bit that the host clears with a one-cycle strobe. There is also a pin output with its own output enable. When the on-chip line decoder is switched on, the pin that otherwise carries negative-rail transmit data is taken over to show the alarm. When the decoder is off, the block releases the pin.

Top module: `ais_detector`

## Requirements
- R1: While `rst` is high, and at the first clock edge where it is sampled high, `ais_live`, `ais_latched`, `ais_pin_o` and `ais_pin_oe` go to 0 and the window restarts. The first strobed bit after reset is bit 0 of a new window.
- R2: Windows are consecutive and do not overlap. Each one holds exactly `WINDOW_BITS` strobed bits. `ais_live` changes only at the clock edge that samples the last strobed bit of a window, and it holds its value at every other edge.
- R3: At the end of a window that holds fewer than `ZERO_THRESH` zeros (a zero is `bit_data` = 0 with `bit_valid` = 1), `ais_live` becomes 1.
- R4: At the end of a window that holds `ZERO_THRESH` or more zeros, `ais_live` becomes 0.
- R5: Cycles with `bit_valid` = 0 neither advance the window nor count a zero, whatever `bit_data` is.
- R6: `ais_latched` becomes 1 at any edge where `ais_live` changes value, whether it rises or falls.
- R7: A high `latch_clr` sampled at an edge clears `ais_latched`. If `ais_live` changes at that same edge, the set wins and `ais_latched` stays 1.
- R8: At each edge, `ais_pin_oe` takes the sampled `coder_en`. `ais_pin_o` takes the new `ais_live` when `coder_en` is 1, and 0 when it is 0.
- R9: The zero count saturates at `ZERO_THRESH`. A window with many more zeros, including an all-zero window, still counts as having enough zeros and clears the alarm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_valid | input | 1 | Strobe qualifying `bit_data` |
| bit_data | input | 1 | Received NRZ data bit |
| coder_en | input | 1 | Line decoder enabled; gives the alarm pin to this block |
| latch_clr | input | 1 | Host clear strobe for `ais_latched` |
| ais_live | output | 1 | Current alarm state |
| ais_latched | output | 1 | Sticky alarm-change event |
| ais_pin_o | output | 1 | Alarm value for the repurposed pin |
| ais_pin_oe | output | 1 | Output enable for the repurposed pin |

## Verification
Two things can happen at the same edge: the host clear of the sticky bit and a change of the live alarm at a window boundary. The bench raises `latch_clr` on exactly the strobe that carries the last bit of a window whose zero count flips the verdict, in both directions. It expects `ais_latched` to remain 1. A second case raises the clear on a boundary that brings no change, and there the bench expects 0. Random runs also mix clear strobes and boundaries, and a cycle-accurate bench model judges every edge.

// File: rtl/ais_pkg.sv
package ais_pkg;
  // Number of bits needed to hold values 0..n inclusive.
  function automatic int cnt_width(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

  localparam int DEF_WINDOW_BITS = 8192;
  localparam int DEF_ZERO_THRESH = 9;
endpackage

// File: rtl/ais_window_ctr.sv
module ais_window_ctr #(
  parameter int WINDOW_BITS = ais_pkg::DEF_WINDOW_BITS
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_valid,
  output logic win_last
);
  localparam int IW = (WINDOW_BITS < 2) ? 1 : $clog2(WINDOW_BITS);
  localparam logic [IW-1:0] LAST_IDX = IW'(WINDOW_BITS - 1);

  logic [IW-1:0] idx_q;

  // High on the strobe that carries the final bit of the current window.
  assign win_last = bit_valid && (idx_q == LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
    end else if (bit_valid) begin
      if (idx_q == LAST_IDX) idx_q <= '0;
      else                   idx_q <= idx_q + 1'b1;
    end
  end
endmodule

// File: rtl/ais_zero_ctr.sv
module ais_zero_ctr #(
  parameter int ZERO_THRESH = ais_pkg::DEF_ZERO_THRESH,
  parameter int ZW          = ais_pkg::cnt_width(ZERO_THRESH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bit_valid,
  input  logic          bit_data,
  input  logic          win_last,
  output logic [ZW-1:0] zcnt_q,
  output logic          enough_zeros
);
  localparam logic [ZW:0] SAT = (ZW+1)'(ZERO_THRESH);

  logic [ZW:0]   sum;
  logic [ZW-1:0] zcnt_inc;

  // Count including the bit on the input this cycle, clamped at the threshold.
  always_comb begin
    sum = {1'b0, zcnt_q} + {{ZW{1'b0}}, (bit_valid && !bit_data)};
    if (sum >= SAT) zcnt_inc = SAT[ZW-1:0];
    else            zcnt_inc = sum[ZW-1:0];
  end

  assign enough_zeros = ({1'b0, zcnt_inc} >= SAT);

  always_ff @(posedge clk) begin
    if (rst) begin
      zcnt_q <= '0;
    end else if (bit_valid) begin
      if (win_last) zcnt_q <= '0;
      else          zcnt_q <= zcnt_inc;
    end
  end
endmodule

// File: rtl/ais_alarm_state.sv
module ais_alarm_state (
  input  logic clk,
  input  logic rst,
  input  logic win_last,
  input  logic enough_zeros,
  input  logic coder_en,
  input  logic latch_clr,
  output logic live_next,
  output logic ais_live,
  output logic ais_latched,
  output logic ais_pin_o,
  output logic ais_pin_oe
);
  // Verdict is taken only at a window boundary; otherwise the state holds.
  assign live_next = win_last ? !enough_zeros : ais_live;

  always_ff @(posedge clk) begin
    if (rst) begin
      ais_live    <= 1'b0;
      ais_latched <= 1'b0;
      ais_pin_o   <= 1'b0;
      ais_pin_oe  <= 1'b0;
    end else begin
      ais_live <= live_next;
      if (live_next != ais_live) ais_latched <= 1'b1;
      else if (latch_clr)        ais_latched <= 1'b0;
      ais_pin_o  <= coder_en & live_next;
      ais_pin_oe <= coder_en;
    end
  end
endmodule

// File: rtl/ais_detector.sv
module ais_detector #(
  parameter int WINDOW_BITS = ais_pkg::DEF_WINDOW_BITS,
  parameter int ZERO_THRESH = ais_pkg::DEF_ZERO_THRESH
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_valid,
  input  logic bit_data,
  input  logic coder_en,
  input  logic latch_clr,
  output logic ais_live,
  output logic ais_latched,
  output logic ais_pin_o,
  output logic ais_pin_oe
);
  localparam int ZW = ais_pkg::cnt_width(ZERO_THRESH);

  logic          win_last;
  logic          enough_zeros;
  logic          live_next;
  logic [ZW-1:0] zcnt_q;

  ais_window_ctr #(.WINDOW_BITS(WINDOW_BITS)) u_win (
    .clk      (clk),
    .rst      (rst),
    .bit_valid(bit_valid),
    .win_last (win_last)
  );

  ais_zero_ctr #(.ZERO_THRESH(ZERO_THRESH), .ZW(ZW)) u_zero (
    .clk         (clk),
    .rst         (rst),
    .bit_valid   (bit_valid),
    .bit_data    (bit_data),
    .win_last    (win_last),
    .zcnt_q      (zcnt_q),
    .enough_zeros(enough_zeros)
  );

  ais_alarm_state u_state (
    .clk         (clk),
    .rst         (rst),
    .win_last    (win_last),
    .enough_zeros(enough_zeros),
    .coder_en    (coder_en),
    .latch_clr   (latch_clr),
    .live_next   (live_next),
    .ais_live    (ais_live),
    .ais_latched (ais_latched),
    .ais_pin_o   (ais_pin_o),
    .ais_pin_oe  (ais_pin_oe)
  );
endmodule

// File: rtl/ais_detector_chk.sv
module ais_detector_chk #(
  parameter int ZW          = 4,
  parameter int ZERO_THRESH = 9
) (
  input logic          clk,
  input logic          rst,
  input logic          coder_en,
  input logic          latch_clr,
  input logic          win_last,
  input logic          live_next,
  input logic [ZW-1:0] zcnt_q,
  input logic          ais_live,
  input logic          ais_latched,
  input logic          ais_pin_o,
  input logic          ais_pin_oe
);
  // R1: reset clears every output
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!ais_live && !ais_latched && !ais_pin_o && !ais_pin_oe));

  // R2: no boundary, no change of the live alarm
  a_r2_hold_mid_window: assert property (@(posedge clk) disable iff (rst)
    !win_last |=> $stable(ais_live));

  // R6: a change of the live alarm leaves the sticky bit set
  a_r6_latch_on_change: assert property (@(posedge clk) disable iff (rst)
    (live_next != ais_live) |=> ais_latched);

  // R7: a clear without a simultaneous change empties the sticky bit
  a_r7_clear_wins_alone: assert property (@(posedge clk) disable iff (rst)
    (latch_clr && (live_next == ais_live)) |=> !ais_latched);

  // R8: pin released when the decoder is off
  a_r8_pin_released: assert property (@(posedge clk) disable iff (rst)
    !coder_en |=> (!ais_pin_oe && !ais_pin_o));

  // R8: pin follows the alarm when the decoder is on
  a_r8_pin_follows: assert property (@(posedge clk) disable iff (rst)
    coder_en |=> (ais_pin_oe && (ais_pin_o == ais_live)));

  // R9: zero count never exceeds the saturation point
  a_r9_zero_saturates: assert property (@(posedge clk) disable iff (rst)
    32'(zcnt_q) <= ZERO_THRESH);
endmodule

bind ais_detector ais_detector_chk #(.ZW(ZW), .ZERO_THRESH(ZERO_THRESH)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .coder_en   (coder_en),
  .latch_clr  (latch_clr),
  .win_last   (win_last),
  .live_next  (live_next),
  .zcnt_q     (zcnt_q),
  .ais_live   (ais_live),
  .ais_latched(ais_latched),
  .ais_pin_o  (ais_pin_o),
  .ais_pin_oe (ais_pin_oe)
);

// File: tb/ais_detector_tb.sv
module ais_detector_tb;
  localparam int WIN = 64;
  localparam int TH  = 9;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_valid = 1'b0, bit_data = 1'b1, coder_en = 1'b0, latch_clr = 1'b0;
  logic ais_live, ais_latched, ais_pin_o, ais_pin_oe;

  int n_tests = 0;
  int n_fail  = 0;

  // bench model
  bit e_live, e_lat, e_pin, e_oe;
  int m_idx, m_zeros;

  always #2.5 clk = ~clk;

  ais_detector #(.WINDOW_BITS(WIN), .ZERO_THRESH(TH)) u_dut (
    .clk(clk), .rst(rst), .bit_valid(bit_valid), .bit_data(bit_data),
    .coder_en(coder_en), .latch_clr(latch_clr), .ais_live(ais_live),
    .ais_latched(ais_latched), .ais_pin_o(ais_pin_o), .ais_pin_oe(ais_pin_oe)
  );

  function automatic bit verdict(input int zeros);
    return zeros < TH;  // R3 / R4
  endfunction

  task automatic compare(input string tag);
    n_tests++;
    if ({ais_live, ais_latched, ais_pin_o, ais_pin_oe} !== {e_live, e_lat, e_pin, e_oe}) begin
      n_fail++;
      $display("FAIL %s: live/lat/pin/oe actual %b%b%b%b expected %b%b%b%b", tag,
               ais_live, ais_latched, ais_pin_o, ais_pin_oe, e_live, e_lat, e_pin, e_oe);
    end
  endtask

  // Drive one cycle at the falling edge, advance the model, judge at the next falling edge.
  task automatic step(input bit v, input bit d, input bit clr, input bit cen, input string tag);
    bit lv;
    bit_valid = v; bit_data = d; latch_clr = clr; coder_en = cen;
    lv = e_live;
    if (v) begin
      int z;
      z = m_zeros + (d ? 0 : 1);
      if (m_idx == WIN - 1) begin
        lv = verdict(z); m_idx = 0; m_zeros = 0;
      end else begin
        m_idx++; m_zeros = z;
      end
    end
    if (lv != e_live) e_lat = 1'b1;
    else if (clr)     e_lat = 1'b0;
    e_live = lv;
    e_pin  = cen & lv;
    e_oe   = cen;
    @(negedge clk);
    compare(tag);
  endtask

  task automatic do_reset(input string tag);
    rst = 1'b1;
    bit_valid = 1'b1; bit_data = 1'b0; latch_clr = 1'b0; coder_en = 1'b1;
    @(negedge clk); @(negedge clk);
    e_live = 0; e_lat = 0; e_pin = 0; e_oe = 0; m_idx = 0; m_zeros = 0;
    compare(tag);
    rst = 1'b0;
  endtask

  // One full window with nz zeros spread by a coprime stride; optional clear on the last bit.
  task automatic send_window(input int nz, input bit clr_last, input bit cen, input string tag);
    for (int i = 0; i < WIN; i++) begin
      bit d;
      d = !(((i * 37) % WIN) < nz);
      step(1'b1, d, clr_last && (i == WIN - 1), cen, tag);
    end
  endtask

  initial begin
    #500000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    process::self().srandom(32'd1234);
    @(negedge clk);
    do_reset("R1 reset state");
    send_window(0,  1'b0, 1'b1, "R3 all ones declares");
    send_window(8,  1'b0, 1'b1, "R3 eight zeros keeps alarm");
    send_window(9,  1'b0, 1'b1, "R4 nine zeros clears");
    send_window(8,  1'b1, 1'b1, "R7 set beats clear at rise");
    send_window(16, 1'b1, 1'b0, "R9 sixteen zeros clears, R7 set beats clear at fall");
    step(1'b0, 1'b0, 1'b1, 1'b0, "R7 clear alone");
    send_window(WIN, 1'b1, 1'b1, "R9 all zeros clears, R7 clear at quiet boundary");
    // R5: zeros on invalid cycles interleaved with a window of ones
    for (int i = 0; i < WIN; i++) begin
      step(1'b0, 1'b0, 1'b0, 1'b1, "R5 invalid zeros ignored");
      step(1'b1, 1'b1, 1'b0, 1'b1, "R5 ones window declares");
    end
    step(1'b0, 1'b0, 1'b0, 1'b0, "R8 pin released");
    step(1'b0, 1'b0, 1'b0, 1'b1, "R8 pin driven");
    // R1: reset mid-window restarts the window
    for (int i = 0; i < 20; i++) step(1'b1, 1'b0, 1'b0, 1'b1, "R2 mid-window hold");
    do_reset("R1 mid-window reset");
    send_window(0, 1'b0, 1'b1, "R1 R2 fresh window after reset");
    // random mix
    for (int i = 0; i < 40 * WIN; i++) begin
      bit v, d, c, en;
      int dens;
      dens = ((i / WIN) % 3 == 0) ? 2 : 40;
      v  = ($urandom % 4) != 0;
      d  = ($urandom % 256) >= dens;
      c  = ($urandom % 16) == 0;
      en = ($urandom % 8) != 0;
      step(v, d, c, en, "R2 R6 R8 random");
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule